// File: doc/BRIEF.md
# Sampling-Based Core Selection Controller

This controller manages four cores that share one instruction set but differ in capability: two narrow in-order designs and two wide out-of-order designs. A single thread runs on exactly one core at a time. The other cores stay powered down. The controller counts completed instruction intervals, which the active core signals with a one-cycle pulse. After a fixed number of normal intervals it opens a sampling window. In that window each core runs one interval in ascending ID order, and its cycle count and energy estimate are latched into a table. The controller then moves the thread to the core with the lowest energy among those whose performance is within 10% of the fastest core. The thread stays there until the next window.

Each move follows the same sequence. The controller powers up the target core and waits a fixed restart delay. It then pulses a state-handoff request for one cycle. On the following cycle it moves run and power to the target and turns the old core off. A busy flag covers the whole sequence. The core IDs run from 0 to 3, and ID 3 is the most capable core. Each core reports its counters on its own 16-bit lane of two flat input buses.

Top module: `core_select_ctrl`

## Requirements
- R1: After synchronous reset the following hold: `active_core` = 3 (highest ID), `run_en` = `pwr_en` = 4'b1000, `busy` = 0, `sampling` = 0, and the interval count is zero.
- R2: Exactly one `run_en` bit is set, at bit `active_core`, and its `pwr_en` bit is also set. When not busy, `pwr_en` equals `run_en`. While busy, exactly two `pwr_en` bits are set: the active core and the target core.
- R3: The `interval_done` pulse that completes the NORMAL_INTERVALS-th normal interval does two things: it raises `sampling` on the next cycle, and it requests a move to core 0.
- R4: In sampling, the intervals run on cores 0, 1, 2, 3 in that order. The window has NUM_CORES+1 intervals. The last interval runs on the chosen core, and `sampling` drops on the cycle after its `interval_done`.
- R5: A move is timed from the accepting `interval_done` edge. `busy` is high for RESTART_CYCLES+1 cycles. `handoff_req` is high for exactly one cycle, the last busy cycle. `active_core` takes the target value on the cycle after that.
- R6: The fastest core is the one with the fewest cycles; on equal cycles the lower ID counts as fastest. A core qualifies when cycles×10 ≤ fastest×11. Equality qualifies.
- R7: Among the qualifying cores, the one with the least energy is chosen. On equal energy the lower ID wins.
- R8: If the requested core equals `active_core`, no move happens and `busy` stays low.
- R9: An `interval_done` that arrives while `busy` is high is ignored. It is counted neither as a normal interval nor as a sampling interval.
- R10: Core c's cycle count is bits [16c+15:16c] of `core_cycles`, and its energy estimate is the same bits of `core_energy`. These are latched when the interval on core c ends during sampling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| interval_done | input | 1 | One-cycle pulse from the active core at the end of an interval |
| core_cycles | input | 64 | Per-core interval cycle counts, 16 bits per core |
| core_energy | input | 64 | Per-core interval energy estimates, 16 bits per core |
| active_core | output | 2 | ID of the core running the thread |
| pwr_en | output | 4 | Power enable, one bit per core |
| run_en | output | 4 | Run enable, one bit per core |
| handoff_req | output | 1 | One-cycle state-handoff request at the end of a move |
| busy | output | 1 | High while a move is in progress |
| sampling | output | 1 | High during the sampling window |

## Verification
Two functions can fall in the same cycle: the latch of the fourth sampled measurement and the winner decision that depends on it. The selector must see the value latched in that same cycle, not the stale table entry. The bench gives each lane distinct counters, so a stale entry or a wrong lane would change the chosen core. The scoreboard catches that change as a wrong value of `active_core`. A second case is an `interval_done` that arrives while a move is in progress. The bench pulses it in the middle of a restart. It then checks that the window order and the `sampling` flag are exactly as they would be if the pulse had never arrived.

// File: rtl/csc_pkg.sv
package csc_pkg;

    parameter int unsigned MEAS_W = 16;

    typedef enum logic [1:0] {
        SW_RUN,
        SW_WAKE,
        SW_HAND
    } sw_state_e;

    typedef enum logic {
        PH_NORMAL,
        PH_SAMPLE
    } phase_e;

    typedef struct packed {
        logic [MEAS_W-1:0] cyc;
        logic [MEAS_W-1:0] nrg;
    } meas_t;

endpackage

// File: rtl/csc_pick.sv
module csc_pick
    import csc_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  meas_t                          tbl [NUM_CORES],
    output logic [$clog2(NUM_CORES)-1:0]   winner
);
    localparam int IDX_W = $clog2(NUM_CORES);
    localparam int XW    = MEAS_W + 4;

    logic [MEAS_W-1:0] best;
    logic [MEAS_W-1:0] win_nrg;
    logic              found;

    always_comb begin
        best = tbl[0].cyc;
        for (int i = 1; i < NUM_CORES; i++) begin
            if (tbl[i].cyc < best) best = tbl[i].cyc;
        end
        found   = 1'b0;
        winner  = '0;
        win_nrg = '0;
        for (int i = 0; i < NUM_CORES; i++) begin
            if (XW'(tbl[i].cyc) * XW'(10) <= XW'(best) * XW'(11)) begin
                if (!found || tbl[i].nrg < win_nrg) begin
                    found   = 1'b1;
                    winner  = IDX_W'(i);
                    win_nrg = tbl[i].nrg;
                end
            end
        end
    end
endmodule

// File: rtl/csc_switch.sv
module csc_switch
    import csc_pkg::*;
#(
    parameter int NUM_CORES      = 4,
    parameter int RESTART_CYCLES = 1000
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          req,
    input  logic [$clog2(NUM_CORES)-1:0]  req_core,
    output logic [$clog2(NUM_CORES)-1:0]  active,
    output logic                          busy,
    output logic                          handoff,
    output logic [NUM_CORES-1:0]          pwr_en,
    output logic [NUM_CORES-1:0]          run_en
);
    localparam int IDX_W = $clog2(NUM_CORES);
    localparam int RCW   = $clog2(RESTART_CYCLES + 1);

    sw_state_e        state;
    logic [IDX_W-1:0] target;
    logic [RCW-1:0]   rcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SW_RUN;
            active <= IDX_W'(NUM_CORES - 1);
            target <= IDX_W'(NUM_CORES - 1);
            rcnt   <= '0;
        end else begin
            case (state)
                SW_RUN: begin
                    if (req && req_core != active) begin
                        target <= req_core;
                        rcnt   <= '0;
                        state  <= SW_WAKE;
                    end
                end
                SW_WAKE: begin
                    if (rcnt == RCW'(RESTART_CYCLES - 1)) state <= SW_HAND;
                    else                                   rcnt  <= rcnt + 1'b1;
                end
                default: begin
                    active <= target;
                    state  <= SW_RUN;
                end
            endcase
        end
    end

    always_comb begin
        busy    = (state != SW_RUN);
        handoff = (state == SW_HAND);
        run_en  = NUM_CORES'(1) << active;
        pwr_en  = run_en | (busy ? (NUM_CORES'(1) << target) : '0);
    end
endmodule

// File: rtl/core_select_ctrl.sv
module core_select_ctrl
    import csc_pkg::*;
#(
    parameter int NUM_CORES        = 4,
    parameter int NORMAL_INTERVALS = 100,
    parameter int RESTART_CYCLES   = 1000
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            interval_done,
    input  logic [NUM_CORES*MEAS_W-1:0]     core_cycles,
    input  logic [NUM_CORES*MEAS_W-1:0]     core_energy,
    output logic [$clog2(NUM_CORES)-1:0]    active_core,
    output logic [NUM_CORES-1:0]            pwr_en,
    output logic [NUM_CORES-1:0]            run_en,
    output logic                            handoff_req,
    output logic                            busy,
    output logic                            sampling
);
    localparam int IDX_W      = $clog2(NUM_CORES);
    localparam int SAMPLE_LEN = NUM_CORES + 1;
    localparam int NCW        = $clog2(NORMAL_INTERVALS + 1);
    localparam int SIW        = $clog2(SAMPLE_LEN + 1);

    meas_t            lane  [NUM_CORES];
    meas_t            tbl_q [NUM_CORES];
    meas_t            tbl_n [NUM_CORES];
    phase_e           phase;
    logic [NCW-1:0]   ivl_cnt;
    logic [SIW-1:0]   samp_idx;
    logic             done_ok;
    logic             latch;
    logic             req;
    logic [IDX_W-1:0] req_core;
    logic [IDX_W-1:0] winner;

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_lane
        assign lane[c].cyc = core_cycles[c*MEAS_W +: MEAS_W];
        assign lane[c].nrg = core_energy[c*MEAS_W +: MEAS_W];
    end

    assign done_ok = interval_done && !busy;
    assign latch   = done_ok && phase == PH_SAMPLE && samp_idx < SIW'(NUM_CORES);

    always_comb begin
        tbl_n = tbl_q;
        if (latch) tbl_n[active_core] = lane[active_core];
    end

    csc_pick #(.NUM_CORES(NUM_CORES)) u_pick (
        .tbl    (tbl_n),
        .winner (winner)
    );

    always_comb begin
        req      = 1'b0;
        req_core = active_core;
        if (done_ok && phase == PH_NORMAL && ivl_cnt == NCW'(NORMAL_INTERVALS - 1)) begin
            req      = 1'b1;
            req_core = '0;
        end else if (latch) begin
            req      = 1'b1;
            req_core = (samp_idx == SIW'(NUM_CORES - 1)) ? winner
                                                         : IDX_W'(samp_idx + 1'b1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_NORMAL;
            ivl_cnt  <= '0;
            samp_idx <= '0;
            for (int i = 0; i < NUM_CORES; i++) tbl_q[i] <= '0;
        end else if (done_ok) begin
            if (phase == PH_NORMAL) begin
                if (ivl_cnt == NCW'(NORMAL_INTERVALS - 1)) begin
                    phase    <= PH_SAMPLE;
                    samp_idx <= '0;
                    ivl_cnt  <= '0;
                end else begin
                    ivl_cnt <= ivl_cnt + 1'b1;
                end
            end else begin
                tbl_q <= tbl_n;
                if (samp_idx == SIW'(SAMPLE_LEN - 1)) begin
                    phase    <= PH_NORMAL;
                    samp_idx <= '0;
                end else begin
                    samp_idx <= samp_idx + 1'b1;
                end
            end
        end
    end

    assign sampling = (phase == PH_SAMPLE);

    csc_switch #(.NUM_CORES(NUM_CORES), .RESTART_CYCLES(RESTART_CYCLES)) u_switch (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .req_core (req_core),
        .active   (active_core),
        .busy     (busy),
        .handoff  (handoff_req),
        .pwr_en   (pwr_en),
        .run_en   (run_en)
    );
endmodule

// File: rtl/csc_chk.sv
module csc_chk #(
    parameter int NUM_CORES = 4
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          interval_done,
    input logic [$clog2(NUM_CORES)-1:0]  active_core,
    input logic [NUM_CORES-1:0]          pwr_en,
    input logic [NUM_CORES-1:0]          run_en,
    input logic                          handoff_req,
    input logic                          busy,
    input logic                          sampling
);
    // R1
    reset_state_chk: assert property (@(posedge clk) rst |=>
        (active_core == $clog2(NUM_CORES)'(NUM_CORES - 1) && !busy && !sampling));

    // R2
    single_runner_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(run_en) == 1 && (run_en & ~pwr_en) == '0);

    // R2
    power_count_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(pwr_en) == (busy ? 2 : 1));

    // R5
    handoff_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        handoff_req |-> busy);

    // R5
    handoff_ends_chk: assert property (@(posedge clk) disable iff (rst)
        handoff_req |=> (!busy && active_core != $past(active_core)));

    // R5
    active_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !handoff_req) |=> $stable(active_core));

    // R9
    busy_done_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && interval_done) |=> $stable(sampling));

    // R8
    switch_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(interval_done));
endmodule

bind core_select_ctrl csc_chk #(.NUM_CORES(NUM_CORES)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .interval_done (interval_done),
    .active_core   (active_core),
    .pwr_en        (pwr_en),
    .run_en        (run_en),
    .handoff_req   (handoff_req),
    .busy          (busy),
    .sampling      (sampling)
);

// File: tb/core_select_ctrl_test.sv
module core_select_ctrl_test;
    localparam int NC = 4;
    localparam int NI = 3;
    localparam int RC = 6;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             interval_done = 1'b0;
    logic [NC*16-1:0] core_cycles = '0;
    logic [NC*16-1:0] core_energy = '0;
    logic [1:0]       active_core;
    logic [NC-1:0]    pwr_en;
    logic [NC-1:0]    run_en;
    logic             handoff_req;
    logic             busy;
    logic             sampling;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    bit finished = 0;

    core_select_ctrl #(.NUM_CORES(NC), .NORMAL_INTERVALS(NI), .RESTART_CYCLES(RC)) uut (
        .clk(clk), .rst(rst), .interval_done(interval_done),
        .core_cycles(core_cycles), .core_energy(core_energy),
        .active_core(active_core), .pwr_en(pwr_en), .run_en(run_en),
        .handoff_req(handoff_req), .busy(busy), .sampling(sampling)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    // monitor side of the scoreboard: every change of active_core is compared
    int prev_active = 3;
    always @(negedge clk) begin
        if (!rst && int'(active_core) != prev_active) begin
            if (exp_q.size() == 0) begin
                chk(0, "R4 unexpected switch", int'(active_core), -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                chk(int'(active_core) == e, "R4/R6/R7 switch target", int'(active_core), e);
            end
            prev_active = int'(active_core);
        end
    end

    task automatic set_lane(input int c, input int cy, input int en);
        core_cycles[c*16 +: 16] = 16'(cy);
        core_energy[c*16 +: 16] = 16'(en);
    endtask

    task automatic pulse_done();
        @(negedge clk) interval_done = 1'b1;
        @(negedge clk) interval_done = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic run_interval();
        wait_idle();
        pulse_done();
    endtask

    // driver side: push expected target, then trigger and time the move
    task automatic switch_to(input int tgt);
        int cnt = 0;
        int hs  = 0;
        int hs_last = 0;
        exp_q.push_back(tgt);
        run_interval();
        while (busy) begin
            cnt++;
            hs_last = handoff_req;
            if (handoff_req) hs++;
            chk($countones(pwr_en) == 2 && pwr_en[tgt], "R2 power during move",
                int'(pwr_en), int'(pwr_en | (4'b1 << tgt)));
            @(negedge clk);
        end
        chk(cnt == RC + 1, "R5 busy length", cnt, RC + 1);
        chk(hs == 1 && hs_last == 1, "R5 handoff pulse", hs, 1);
        chk(pwr_en == run_en && run_en == (4'b1 << tgt), "R2 enables after move",
            int'(pwr_en), int'(4'b1 << tgt));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(active_core == 2'd3, "R1 active", int'(active_core), 3);
        chk(pwr_en == 4'b1000 && run_en == 4'b1000, "R1 enables", int'(pwr_en), 8);
        chk(!busy && !sampling, "R1 flags", int'({busy, sampling}), 0);

        // round A: R6 boundary (110 vs 100 qualifies, 150 does not), R7 energy, R10 lanes
        set_lane(0, 200, 10); set_lane(1, 150, 20); set_lane(2, 110, 30); set_lane(3, 100, 80);
        run_interval();
        run_interval();
        chk(!sampling && !busy, "R3 no sampling before limit", int'(sampling), 0);
        switch_to(0);
        chk(sampling == 1'b1, "R3 sampling entered", int'(sampling), 1);
        switch_to(1);
        switch_to(2);
        exp_q.push_back(3);
        run_interval();
        @(negedge clk);
        chk(busy == 1'b1, "R9 busy before stray pulse", int'(busy), 1);
        pulse_done();
        wait_idle();
        chk(active_core == 2'd3 && sampling, "R9 stray pulse ignored", int'(active_core), 3);
        switch_to(2);
        chk(active_core == 2'd2, "R6 margin boundary winner", int'(active_core), 2);
        run_interval();
        chk(!sampling, "R4 window closes after settle", int'(sampling), 0);

        // round B: full tie on cycles and energy, R7 lowest ID wins
        for (int c = 0; c < NC; c++) set_lane(c, 100, 5);
        run_interval();
        run_interval();
        switch_to(0);
        switch_to(1);
        switch_to(2);
        switch_to(3);
        switch_to(0);
        chk(active_core == 2'd0, "R7 tie to lower ID", int'(active_core), 0);
        run_interval();
        chk(!sampling, "R4 window closes", int'(sampling), 0);

        // round C: already on core 0 at window start, and winner equals last sampled core
        set_lane(0, 300, 1); set_lane(1, 300, 1); set_lane(2, 300, 1); set_lane(3, 100, 50);
        run_interval();
        run_interval();
        run_interval();
        chk(!busy && sampling, "R8 no move to same core", int'(busy), 0);
        switch_to(1);
        switch_to(2);
        switch_to(3);
        run_interval();
        chk(!busy && active_core == 2'd3, "R8 winner is current core", int'(busy), 0);
        chk(sampling == 1'b1, "R4 settle interval pending", int'(sampling), 1);
        run_interval();
        chk(!sampling, "R4 window closes", int'(sampling), 0);

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R4 all expected moves seen", exp_q.size(), 0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule